// File: doc/BRIEF.md
# Byte-Aligned Boundary-Scan Serial Shifter

This block sits between a byte-wide host port and a serial boundary-scan chain. The host places a byte in an outbound buffer, and the block sends it to the chain one bit at a time, least significant bit first, on the serial output `tdo`. Bits coming back from the chain on `tdi` are packed into an inbound byte. When that byte is full, it is handed to the host through a read register with a data-available flag. The block also drives the chain's test clock `tck`. This clock is a gated copy of the system clock, so it never runs faster than the system clock. It pulses only while an enabled shifter has work to do.

Both shifters are kept in step by one shared bit counter that counts within the byte. The counter advances once per test-clock pulse and wraps at the byte boundary. A shifter that becomes active partway through a byte joins at the counter's current position. It therefore handles only the remaining bits of that byte, not a fresh full byte.

Two mode bits choose which shifters take part. Changes to them are accepted only while the test clock is stopped. A control state machine has two states:
- `S_IDLE`: the clock is stopped and the counter is at zero.
- `S_SHIFT`: the clock is running.

It has two transitions:
- *start* (`S_IDLE` → `S_SHIFT`): taken when an enabled shifter has work.
- *wrap* (`S_SHIFT` → `S_IDLE`): taken on the last bit of every byte.

After a wrap, the machine starts again on the next cycle if there is still work.

Top module: `scan_byte_shifter`

## Requirements
- R1: After reset:
  - `tck` is low and `tdo` is high.
  - `tx_ready` is high, `rx_avail` is low and `mode_err` is low.
  - Both mode enables are clear.
- R2: `tck` is high only while the system clock is high. It pulses exactly once per shifted bit. A full byte gives exactly 8 pulses, and the clock then stops at the byte boundary.
- R3: The outbound byte leaves on `tdo` least significant bit first. `tdo` changes only on falling system-clock edges, so it is stable at every `tck` rise. `tdo` is 1 whenever the outbound shifter is not active.
- R4: `tdi` is sampled on the system-clock rising edge that coincides with each `tck` rise. After 8 samples, the first bit received sits in bit 0 of `rx_data` and `rx_avail` rises.
- R5: Inbound capture runs only when the inbound enable is set and the read register is empty. While `rx_avail` is high, `rx_data` holds its value and `tck` stays stopped if no other work exists. `rx_rd` clears `rx_avail` on the next edge.
- R6: One shared counter aligns both shifters. If the outbound shifter becomes active while the counter reads c, it sends exactly 8−c bits (bits 0 to 7−c of its byte) before the boundary. With c = 3 it sends 5 bits.
- R7: A mode write while `tck` runs leaves the mode unchanged and sets `mode_err`. `mode_err` stays set until reset. A mode write while the clock is stopped takes effect. `mode_wdata` bit 0 enables the outbound shifter and bit 1 enables the inbound shifter.
- R8: `tck` runs only when the outbound enable is set with a loaded buffer, or the inbound enable is set with an empty read register. A loaded byte with the outbound enable clear produces no pulses and keeps `tx_ready` low.
- R9: `tx_ready` drops on the edge that accepts a load (`tx_valid` while `tx_ready`). It returns high on the edge that shifts the last bit of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode value: bit 0 enables outbound, bit 1 enables inbound |
| tx_valid | input | 1 | Outbound byte offered |
| tx_data | input | 8 | Outbound byte |
| tx_ready | output | 1 | Outbound buffer empty, load accepted |
| rx_rd | input | 1 | Host read of the inbound byte |
| rx_data | output | 8 | Last complete inbound byte |
| rx_avail | output | 1 | Inbound byte waiting to be read |
| tdi | input | 1 | Serial data returning from the chain |
| tdo | output | 1 | Serial data to the chain |
| tck | output | 1 | Gated test clock |
| mode_err | output | 1 | Sticky flag: mode write rejected while shifting |

## Verification
The outbound buffer is loaded on edge E0. The start transition follows on E1, the first `tck` rise comes on E2, and the eighth rise comes on E9, where `tx_ready` also returns. `rx_avail` rises on the same edge as the eighth rise of an inbound byte, and a read clears it one edge later.

The bench drives inputs and samples flags on falling clock edges. It records `tdo` and `tdi` at every `tck` rise, so serial checks compare the recorded bits against bench-computed bytes rather than counting absolute cycles. For the mid-byte case, the bench offers the load after the second rise of a byte, so the buffer becomes active with the counter at 3. It then expects exactly five data bits on rises four to eight.

// File: rtl/scan_shift_pkg.sv
package scan_shift_pkg;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_SHIFT = 1'b1
    } scan_state_t;

    typedef struct packed {
        logic rx_on;   // bit 1: inbound shifter enable
        logic tx_on;   // bit 0: outbound shifter enable
    } scan_mode_t;

endpackage

// File: rtl/scan_shift_ctrl.sv
module scan_shift_ctrl
    import scan_shift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_we,
    input  logic [1:0] mode_wdata,
    input  logic       tx_act,
    input  logic       rx_act,
    output logic       run,
    output logic       last,
    output scan_mode_t mode,
    output logic       mode_err
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DATA_W - 1);

    scan_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;
    scan_mode_t mode_q;
    logic err_q;

    // state register, bit counter, mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cnt    <= '0;
            mode_q <= '0;
            err_q  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_SHIFT)
                cnt <= last ? '0 : cnt + CNT_W'(1);
            if (mode_we) begin
                if (state == S_IDLE) mode_q <= scan_mode_t'(mode_wdata);
                else                 err_q  <= 1'b1;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        run      = 1'b0;
        last     = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (tx_act || rx_act) state_nx = S_SHIFT;   // start
            end
            S_SHIFT: begin
                run  = 1'b1;
                last = (cnt == LAST_POS);
                if (last) state_nx = S_IDLE;                // wrap
            end
            default: state_nx = S_IDLE;
        endcase
    end

    assign mode     = mode_q;
    assign mode_err = err_q;

    p_cnt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (cnt == '0))
        else $error("counter not at byte boundary while idle");

    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT) |=> $stable(mode_q))
        else $error("mode changed while shifting");

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q)
        else $error("mode error flag cleared");

    p_shift_work_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SHIFT) |-> (tx_act || rx_act))
        else $error("shifting with no active shifter");

endmodule

// File: rtl/scan_shift_tx.sv
module scan_shift_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              run,
    input  logic              last,
    input  logic              load_valid,
    input  logic [DATA_W-1:0] load_data,
    output logic              ready,
    output logic              active,
    output logic              bit_out
);
    logic [DATA_W-1:0] sr;
    logic              full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr   <= '0;
            full <= 1'b0;
        end else if (load_valid && !full) begin
            sr   <= load_data;
            full <= 1'b1;
        end else if (run && active) begin
            sr <= {1'b0, sr[DATA_W-1:1]};
            if (last) full <= 1'b0;
        end
    end

    assign ready   = !full;
    assign active  = en && full;
    assign bit_out = sr[0];

    p_ready_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !(run && active && last)) |=> !ready)
        else $error("outbound buffer released early");

    p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && active && last) |=> ready)
        else $error("outbound buffer not released at boundary");

endmodule

// File: rtl/scan_shift_rx.sv
module scan_shift_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              run,
    input  logic              last,
    input  logic              sin,
    input  logic              rd,
    output logic [DATA_W-1:0] data,
    output logic              avail,
    output logic              active
);
    logic [DATA_W-1:0] sr;
    logic [DATA_W-1:0] sr_nx;

    assign sr_nx  = {sin, sr[DATA_W-1:1]};
    assign active = en && !avail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr    <= '0;
            data  <= '0;
            avail <= 1'b0;
        end else begin
            if (run && active) begin
                sr <= sr_nx;
                if (last) begin
                    data  <= sr_nx;
                    avail <= 1'b1;
                end
            end
            if (rd && avail) avail <= 1'b0;
        end
    end

    p_avail_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && avail) |=> !avail)
        else $error("read did not clear data-available");

    p_hold_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (avail && !rd) |=> $stable(data))
        else $error("inbound byte overwritten while unread");

endmodule

// File: rtl/scan_shift_gate.sv
module scan_shift_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tx_act,
    input  logic tx_bit,
    output logic tck,
    output logic tdo
);
    logic gate_q;
    logic tdo_q;

    // falling-edge flops: glitch-free gate and serial output timing
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            tdo_q  <= 1'b1;
        end else begin
            gate_q <= run;
            tdo_q  <= tx_act ? tx_bit : 1'b1;
        end
    end

    assign tck = clk & gate_q;
    assign tdo = tdo_q;

    p_gate_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q == run)
        else $error("test clock pulse without a shift cycle");

endmodule

// File: rtl/scan_byte_shifter.sv
module scan_byte_shifter
    import scan_shift_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [1:0]        mode_wdata,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_avail,
    input  logic              tdi,
    output logic              tdo,
    output logic              tck,
    output logic              mode_err
);
    scan_mode_t mode;
    logic run, last;
    logic tx_act, rx_act, tx_bit;

    scan_shift_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .tx_act(tx_act), .rx_act(rx_act),
        .run(run), .last(last),
        .mode(mode), .mode_err(mode_err)
    );

    scan_shift_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .en(mode.tx_on), .run(run), .last(last),
        .load_valid(tx_valid), .load_data(tx_data),
        .ready(tx_ready), .active(tx_act), .bit_out(tx_bit)
    );

    scan_shift_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .en(mode.rx_on), .run(run), .last(last),
        .sin(tdi), .rd(rx_rd),
        .data(rx_data), .avail(rx_avail), .active(rx_act)
    );

    scan_shift_gate u_gate (
        .clk(clk), .rst_n(rst_n),
        .run(run), .tx_act(tx_act), .tx_bit(tx_bit),
        .tck(tck), .tdo(tdo)
    );

endmodule

// File: tb/scan_byte_shifter_tb.sv
module scan_byte_shifter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [1:0] mode_wdata = 2'b00;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_avail;
    logic       tdi = 1'b0;
    logic       tdo;
    logic       tck;
    logic       mode_err;

    int total = 0;
    int bad = 0;
    int rc = 0;
    bit done = 1'b0;
    bit mon_tdo [4096];
    bit mon_tdi [4096];

    always #4 clk = ~clk;   // 125 MHz

    scan_byte_shifter #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_avail(rx_avail),
        .tdi(tdi), .tdo(tdo), .tck(tck), .mode_err(mode_err)
    );

    // record serial lines at every test-clock rise
    initial forever begin
        @(posedge tck);
        mon_tdo[rc % 4096] = tdo;
        mon_tdi[rc % 4096] = tdi;
        if (clk !== 1'b1) begin
            total++; bad++;
            $display("FAIL R2 tck rose with clk=%0b expected=1", clk);
        end
        rc++;
    end

    // chain model: new return bit on each test-clock fall
    initial forever begin
        @(negedge tck);
        tdi = 1'($urandom % 2);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] tdi_byte(input int base);
        logic [7:0] r = '0;
        for (int i = 0; i < 8; i++) r[i] = mon_tdi[(base + i) % 4096];
        return r;
    endfunction

    function automatic logic [7:0] tdo_bits(input int base, input int n);
        logic [7:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = mon_tdo[(base + i) % 4096];
        return r;
    endfunction

    function automatic logic [7:0] low_bits(input logic [7:0] d, input int n);
        return d & 8'((1 << n) - 1);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode_we = 1'b1; mode_wdata = m;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic load_tx(input logic [7:0] d);
        @(negedge clk); tx_valid = 1'b1; tx_data = d;
        @(negedge clk); tx_valid = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_avail();
        for (int i = 0; i < 60 && !rx_avail; i++) @(negedge clk);
    endtask

    task automatic wait_rc(input int target);
        for (int i = 0; i < 60 && rc < target; i++) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d);
        int base;
        base = rc;
        load_tx(d);
        chk("R9 ready low after load", tx_ready, 1'b0);
        idle(14);
        chk("R2 eight pulses per byte", rc - base, 8);
        chk("R3 lsb-first byte on tdo", tdo_bits(base, 8), d);
        chk("R9 ready back after byte", tx_ready, 1'b1);
        chk("R3 tdo idle high", tdo, 1'b1);
    endtask

    initial begin
        int base, r0;
        logic [7:0] d, held;
        void'($urandom(32'd1337));
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk("R1 tck low", tck, 1'b0);
        chk("R1 tdo high", tdo, 1'b1);
        chk("R1 tx_ready", tx_ready, 1'b1);
        chk("R1 rx_avail", rx_avail, 1'b0);
        chk("R1 mode_err", mode_err, 1'b0);
        chk("R1 no pulses with mode clear", rc, 0);

        // R8: loaded byte, outbound disabled -> no clock
        base = rc;
        load_tx(8'h5A);
        idle(20);
        chk("R8 no pulses while disabled", rc - base, 0);
        chk("R8 buffer held", tx_ready, 1'b0);
        set_mode(2'b01);
        idle(14);
        chk("R2 eight pulses after enable", rc - base, 8);
        chk("R3 byte 5A lsb first", tdo_bits(base, 8), 8'h5A);
        chk("R9 ready after byte", tx_ready, 1'b1);

        // constrained random outbound bytes
        send_byte(8'h80);
        send_byte(8'h01);
        for (int k = 0; k < 6; k++) begin
            d = 8'($urandom);
            send_byte(d);
            idle(int'($urandom % 4));
        end

        // R4/R5 inbound capture
        set_mode(2'b10);
        chk("R7 write while stopped no error", mode_err, 1'b0);
        for (int k = 0; k < 4; k++) begin
            wait_avail();
            chk("R4 rx_avail raised", rx_avail, 1'b1);
            chk("R4 rx byte first bit in bit0", rx_data, tdi_byte(rc - 8));
            r0 = rc; held = rx_data;
            idle(5);
            chk("R5 clock stopped while full", rc - r0, 0);
            chk("R5 rx_data held", rx_data, held);
            if (k < 3) begin
                read_rx();
                chk("R5 read clears avail", rx_avail, 1'b0);
            end
        end

        // R6 mid-byte enable: outbound active with counter at 3
        set_mode(2'b11);
        chk("R7 write while stopped no error", mode_err, 1'b0);
        base = rc;
        d = 8'hB6;
        read_rx();
        wait_rc(base + 2);
        tx_valid = 1'b1; tx_data = d;
        @(negedge clk); tx_valid = 1'b0;
        chk("R6 load during rise three", rc - base, 3);
        wait_rc(base + 5);
        mode_we = 1'b1; mode_wdata = 2'b00;
        @(negedge clk); mode_we = 1'b0;
        chk("R7 write during shift flags error", mode_err, 1'b1);
        wait_avail();
        chk("R6 byte ends after 8 pulses", rc - base, 8);
        chk("R6 five bits sent from counter 3", tdo_bits(base + 3, 5), low_bits(d, 5));
        chk("R3 tdo high before outbound active", tdo_bits(base, 3), 8'h07);
        chk("R6 buffer released at boundary", tx_ready, 1'b1);
        chk("R4 rx byte alongside tx", rx_data, tdi_byte(base));

        // R7 rejected write left inbound enabled
        base = rc;
        read_rx();
        idle(12);
        chk("R7 mode kept after rejected write", rc - base, 8);
        chk("R7 error flag sticky", mode_err, 1'b1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule